// File: doc/BRIEF.md
# Processor Hotplug Event Register Controller

This block gives firmware a compact register window over a fixed array of processor slots. Each slot carries a present bit, an insert-event flag, a remove-event flag and two 32-bit words that firmware fills in to report how it handled the last event. Firmware points a selector at a slot, then reads or writes the flags, command and data locations to inspect it, acknowledge its events, ask for ejection or record its status words.

The hardware side reports plug, removal-request and removal-complete activity per slot. A hot plug or a removal request leaves an event pending, and a level interrupt stays high while any event is pending. Firmware finds the pending slots with a search command. The search walks the slots round-robin from the current selector, leaves the first slot with an event in the selector, and that index is read back through the data location. An eject write gives a one-cycle eject strobe with the slot number. A status write gives a one-cycle notification that carries both status words.

Top module: `proc_hotplug_ctrl`

## Requirements
- R1: After reset, every slot reads flags 0, the interrupt is low, the selector is 0 and the command is 0 (find), so a data read returns 0.
- R2: The window decodes byte offsets 0 (selector, write), 4 (flags), 5 (command, write) and 8 (data). A flags read returns bit 0 = present, bit 1 = insert pending and bit 2 = remove pending, with all other bits 0. Reads at any other offset return 0.
- R3: A flags write is decoded by priority. If bit 1 is set, the insert event is cleared. Otherwise, if bit 2 is set, the remove event is cleared. Otherwise, if bit 3 is set, ejection is requested.
- R4: An ejection request on a present slot gives `eject_pulse` high for exactly one cycle, in the cycle after the write, with `eject_slot` = selector. On a slot that is not present it gives no pulse.
- R5: A command write takes bits 7:0 of the written value. Codes 0 (find), 1 (write event word) and 2 (write status word) are stored. Codes of 3 or more are ignored and the stored command is kept.
- R6: Writing command 0 scans slots for a pending insert or remove event. The scan starts at the selector itself, steps upward and wraps to 0 after the last slot. The first slot found is loaded into the selector. If no slot has an event, the selector is unchanged.
- R7: A data read returns the selector when the command is 0, and 0 for any other command.
- R8: A data write stores the value as the selected slot's event word under command 1, and as its status word under command 2. The status write makes `ost_valid` high for one cycle after the write, with the slot, the new status word and the stored event word.
- R9: While the selector is at or above the slot count, every read returns 0 and every write to an offset other than 0 is dropped.
- R10: `plug_valid` sets the slot's present bit, and also sets its insert event when `plug_hot` is 1. `rmreq_valid` sets the remove event. `rmdone_valid` clears the present bit.
- R11: `event_irq` is high exactly while at least one slot has an insert or remove event pending.
- R12: When a hardware input sets an event in the same cycle as a firmware write clears that event on the same slot, the event remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte offset into the register window |
| bus_wr | input | 1 | Write strobe for the addressed location |
| bus_wdata | input | 32 | Write value |
| bus_rdata | output | 32 | Combinational read value at bus_addr |
| plug_valid | input | 1 | A slot has been populated |
| plug_hot | input | 1 | The population is a hot addition (raise insert event) |
| plug_slot | input | 3 | Slot index for plug_valid |
| rmreq_valid | input | 1 | Removal of a slot is requested |
| rmreq_slot | input | 3 | Slot index for rmreq_valid |
| rmdone_valid | input | 1 | Removal of a slot has completed |
| rmdone_slot | input | 3 | Slot index for rmdone_valid |
| event_irq | output | 1 | High while any event is pending |
| eject_pulse | output | 1 | One-cycle eject strobe |
| eject_slot | output | 3 | Slot to eject |
| ost_valid | output | 1 | One-cycle status-write notification |
| ost_slot | output | 3 | Slot of the notification |
| ost_event | output | 32 | Stored event word of that slot |
| ost_status | output | 32 | Newly written status word |

## Verification
Two things can act on the same slot flag in one cycle. A firmware flags write can clear an event while a hardware plug or removal request sets that event. The bench drives a hot plug and an insert-clear write for the same slot on the same clock edge, and does the same with a removal request against a remove-clear. It then reads the flags back through the window and expects the event still pending, with the interrupt still high. A later clear on its own must then drop the event.

// File: rtl/hp_pkg.sv
// Package: shared offsets, flag bit positions and command codes of the
// processor hotplug register window. Assumes byte offsets within a 16-byte
// decode space.
package hp_pkg;
    localparam logic [3:0] OFS_SEL   = 4'd0;
    localparam logic [3:0] OFS_FLAGS = 4'd4;
    localparam logic [3:0] OFS_CMD   = 4'd5;
    localparam logic [3:0] OFS_DATA  = 4'd8;

    localparam int FLG_PRESENT = 0;
    localparam int FLG_INS     = 1;
    localparam int FLG_REM     = 2;
    localparam int FLG_EJECT   = 3;

    typedef enum logic [7:0] {
        CMD_FIND   = 8'd0,
        CMD_OST_EV = 8'd1,
        CMD_OST_ST = 8'd2
    } hp_cmd_e;

    localparam logic [7:0] CMD_LIMIT = 8'd3;
endpackage

// File: rtl/hp_slot_bank.sv
// Module: per-slot state of the hotplug controller (present bit, insert and
// remove events, event and status words). Hardware set requests win over
// firmware clears that hit the same slot in the same cycle. Assumes the
// firmware strobes are one-hot or zero.
module hp_slot_bank #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           plug_valid,
    input  logic                           plug_hot,
    input  logic [IDX_W-1:0]               plug_slot,
    input  logic                           rmreq_valid,
    input  logic [IDX_W-1:0]               rmreq_slot,
    input  logic                           rmdone_valid,
    input  logic [IDX_W-1:0]               rmdone_slot,
    input  logic [SLOTS-1:0]               fw_clr_ins,
    input  logic [SLOTS-1:0]               fw_clr_rem,
    input  logic [SLOTS-1:0]               fw_ev_we,
    input  logic [SLOTS-1:0]               fw_st_we,
    input  logic [DATA_W-1:0]              fw_wdata,
    output logic [SLOTS-1:0]               present_o,
    output logic [SLOTS-1:0]               ins_o,
    output logic [SLOTS-1:0]               rem_o,
    output logic [SLOTS-1:0][DATA_W-1:0]   ost_ev_o,
    output logic [SLOTS-1:0][DATA_W-1:0]   ost_st_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic              present_q, ins_q, rem_q;
        logic [DATA_W-1:0] ev_q, st_q;
        logic              hit_plug, hit_rmreq, hit_rmdone;

        assign hit_plug   = plug_valid   && (int'(plug_slot)   == g);
        assign hit_rmreq  = rmreq_valid  && (int'(rmreq_slot)  == g);
        assign hit_rmdone = rmdone_valid && (int'(rmdone_slot) == g);

        // Slot flags: hardware sets take priority over clears.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                present_q <= 1'b0;
                ins_q     <= 1'b0;
                rem_q     <= 1'b0;
            end else begin
                if (hit_plug)        present_q <= 1'b1;
                else if (hit_rmdone) present_q <= 1'b0;
                if (hit_plug && plug_hot) ins_q <= 1'b1;
                else if (fw_clr_ins[g])   ins_q <= 1'b0;
                if (hit_rmreq)          rem_q <= 1'b1;
                else if (fw_clr_rem[g]) rem_q <= 1'b0;
            end
        end

        // Firmware-reported event and status words.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ev_q <= '0;
                st_q <= '0;
            end else begin
                if (fw_ev_we[g]) ev_q <= fw_wdata;
                if (fw_st_we[g]) st_q <= fw_wdata;
            end
        end

        assign present_o[g] = present_q;
        assign ins_o[g]     = ins_q;
        assign rem_o[g]     = rem_q;
        assign ost_ev_o[g]  = ev_q;
        assign ost_st_o[g]  = st_q;
    end

    AST_HOT_PLUG_SETS_INS: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_valid && plug_hot && (int'(plug_slot) < SLOTS))
        |=> ins_o[$past(plug_slot)]); // R10

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rmreq_valid && (int'(rmreq_slot) < SLOTS))
        |=> rem_o[$past(rmreq_slot)]); // R12
endmodule

// File: rtl/hp_event_finder.sv
// Module: round-robin search for the next slot with an event pending.
// Checks slots start, start+1, ... wrapping after SLOTS-1; the lowest
// distance from start wins. Assumes start < SLOTS.
module hp_event_finder #(
    parameter int SLOTS  = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0] pending,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] found_idx
);
    logic [IDX_W:0] cand;

    // Rotated priority scan: walk distances high to low so the nearest wins.
    always_comb begin
        found     = 1'b0;
        found_idx = start;
        cand      = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            cand = {1'b0, start} + (IDX_W + 1)'(k);
            if (int'(cand) >= SLOTS) cand = cand - (IDX_W + 1)'(SLOTS);
            if (pending[cand[IDX_W-1:0]]) begin
                found     = 1'b1;
                found_idx = cand[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/proc_hotplug_ctrl.sv
// Module: processor hotplug register window. Decodes selector, flags,
// command and data accesses, runs the event search, and drives the
// interrupt, eject strobe and status notification. Assumes one full-width
// access per cycle at a decoded byte offset; byte merging is external.
module proc_hotplug_ctrl #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              plug_valid,
    input  logic              plug_hot,
    input  logic [IDX_W-1:0]  plug_slot,
    input  logic              rmreq_valid,
    input  logic [IDX_W-1:0]  rmreq_slot,
    input  logic              rmdone_valid,
    input  logic [IDX_W-1:0]  rmdone_slot,
    output logic              event_irq,
    output logic              eject_pulse,
    output logic [IDX_W-1:0]  eject_slot,
    output logic              ost_valid,
    output logic [IDX_W-1:0]  ost_slot,
    output logic [DATA_W-1:0] ost_event,
    output logic [DATA_W-1:0] ost_status
);
    import hp_pkg::*;

    logic [DATA_W-1:0]             sel_q;
    hp_cmd_e                       cmd_q;
    logic                          sel_ok;
    logic [IDX_W-1:0]              sel_idx;
    logic [SLOTS-1:0]              sel_onehot;
    logic                          wr_sel, wr_flg, wr_cmd, wr_dat;
    logic [7:0]                    cmd_byte;
    logic                          cmd_legal;
    logic [SLOTS-1:0]              clr_ins, clr_rem, ev_we, st_we;
    logic                          eject_req;
    logic [SLOTS-1:0]              present_v, ins_v, rem_v;
    logic [SLOTS-1:0][DATA_W-1:0]  ev_v, st_v;
    logic                          scan_hit;
    logic [IDX_W-1:0]              scan_idx;

    assign sel_ok     = (sel_q < DATA_W'(SLOTS));
    assign sel_idx    = sel_q[IDX_W-1:0];
    assign sel_onehot = SLOTS'(1) << sel_idx;
    assign cmd_byte   = bus_wdata[7:0];
    assign cmd_legal  = (cmd_byte < CMD_LIMIT);

    // Write decode: anything but the selector needs a valid selector.
    always_comb begin
        wr_sel = bus_wr && (bus_addr == OFS_SEL);
        wr_flg = bus_wr && sel_ok && (bus_addr == OFS_FLAGS);
        wr_cmd = bus_wr && sel_ok && (bus_addr == OFS_CMD);
        wr_dat = bus_wr && sel_ok && (bus_addr == OFS_DATA);
    end

    // Flags write priority: insert clear, then remove clear, then eject.
    always_comb begin
        clr_ins   = '0;
        clr_rem   = '0;
        eject_req = 1'b0;
        if (wr_flg) begin
            if (bus_wdata[FLG_INS])      clr_ins = sel_onehot;
            else if (bus_wdata[FLG_REM]) clr_rem = sel_onehot;
            else if (bus_wdata[FLG_EJECT]) eject_req = present_v[sel_idx];
        end
    end

    // Data write steering by current command.
    always_comb begin
        ev_we = (wr_dat && cmd_q == CMD_OST_EV) ? sel_onehot : '0;
        st_we = (wr_dat && cmd_q == CMD_OST_ST) ? sel_onehot : '0;
    end

    hp_slot_bank #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .plug_valid   (plug_valid),
        .plug_hot     (plug_hot),
        .plug_slot    (plug_slot),
        .rmreq_valid  (rmreq_valid),
        .rmreq_slot   (rmreq_slot),
        .rmdone_valid (rmdone_valid),
        .rmdone_slot  (rmdone_slot),
        .fw_clr_ins   (clr_ins),
        .fw_clr_rem   (clr_rem),
        .fw_ev_we     (ev_we),
        .fw_st_we     (st_we),
        .fw_wdata     (bus_wdata),
        .present_o    (present_v),
        .ins_o        (ins_v),
        .rem_o        (rem_v),
        .ost_ev_o     (ev_v),
        .ost_st_o     (st_v)
    );

    hp_event_finder #(.SLOTS(SLOTS)) u_find (
        .pending   (ins_v | rem_v),
        .start     (sel_idx),
        .found     (scan_hit),
        .found_idx (scan_idx)
    );

    // Selector and command registers, including the search result load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            cmd_q <= CMD_FIND;
        end else if (wr_sel) begin
            sel_q <= bus_wdata;
        end else if (wr_cmd && cmd_legal) begin
            cmd_q <= hp_cmd_e'(cmd_byte);
            if (cmd_byte == CMD_FIND && scan_hit)
                sel_q <= DATA_W'(scan_idx);
        end
    end

    // One-cycle eject strobe and status notification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eject_pulse <= 1'b0;
            eject_slot  <= '0;
            ost_valid   <= 1'b0;
            ost_slot    <= '0;
            ost_event   <= '0;
            ost_status  <= '0;
        end else begin
            eject_pulse <= eject_req;
            if (eject_req) eject_slot <= sel_idx;
            ost_valid <= |st_we;
            if (|st_we) begin
                ost_slot   <= sel_idx;
                ost_event  <= ev_v[sel_idx];
                ost_status <= bus_wdata;
            end
        end
    end

    // Read mux: zero for an out-of-range selector or undecoded offset.
    always_comb begin
        bus_rdata = '0;
        if (sel_ok) begin
            case (bus_addr)
                OFS_FLAGS: begin
                    bus_rdata[FLG_PRESENT] = present_v[sel_idx];
                    bus_rdata[FLG_INS]     = ins_v[sel_idx];
                    bus_rdata[FLG_REM]     = rem_v[sel_idx];
                end
                OFS_DATA: bus_rdata = (cmd_q == CMD_FIND) ? sel_q : '0;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign event_irq = |(ins_v | rem_v);

    AST_EJECT_NEEDS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        eject_pulse |-> $past(present_v[sel_idx])); // R4

    AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CMD && bus_wdata[7:0] >= CMD_LIMIT)
        |=> $stable(cmd_q)); // R5

    AST_SEARCH_LANDS_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && cmd_byte == CMD_FIND && |(ins_v | rem_v))
        |=> (ins_v[sel_idx] || rem_v[sel_idx])); // R6

    AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok |-> (bus_rdata == '0)); // R9

    AST_OST_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ost_valid |-> $past(wr_dat && cmd_q == CMD_OST_ST)); // R8
endmodule

// File: tb/proc_hotplug_ctrl_test.sv
`timescale 1ns/1ps
module proc_hotplug_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        plug_valid = 1'b0, plug_hot = 1'b0;
    logic [2:0]  plug_slot = '0;
    logic        rmreq_valid = 1'b0;
    logic [2:0]  rmreq_slot = '0;
    logic        rmdone_valid = 1'b0;
    logic [2:0]  rmdone_slot = '0;
    logic        event_irq, eject_pulse, ost_valid;
    logic [2:0]  eject_slot, ost_slot;
    logic [31:0] ost_event, ost_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    proc_hotplug_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .plug_valid(plug_valid), .plug_hot(plug_hot), .plug_slot(plug_slot),
        .rmreq_valid(rmreq_valid), .rmreq_slot(rmreq_slot),
        .rmdone_valid(rmdone_valid), .rmdone_slot(rmdone_slot),
        .event_irq(event_irq), .eject_pulse(eject_pulse), .eject_slot(eject_slot),
        .ost_valid(ost_valid), .ost_slot(ost_slot), .ost_event(ost_event),
        .ost_status(ost_status)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic hw_plug(logic [2:0] s, logic hot);
        @(negedge clk);
        plug_valid = 1'b1; plug_slot = s; plug_hot = hot;
        @(negedge clk);
        plug_valid = 1'b0; plug_hot = 1'b0;
    endtask

    task automatic hw_rmreq(logic [2:0] s);
        @(negedge clk);
        rmreq_valid = 1'b1; rmreq_slot = s;
        @(negedge clk);
        rmreq_valid = 1'b0;
    endtask

    task automatic hw_rmdone(logic [2:0] s);
        @(negedge clk);
        rmdone_valid = 1'b1; rmdone_slot = s;
        @(negedge clk);
        rmdone_valid = 1'b0;
    endtask

    task automatic flags_of(logic [31:0] s, output logic [31:0] f);
        wr(4'd0, s);
        rd(4'd4, f);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 8; s++) begin
            flags_of(s, v);
            chk("R1 flags after reset", v, 0);
        end
        wr(4'd0, 0);
        rd(4'd8, v); chk("R1 data after reset", v, 0);
        chk("R1 irq after reset", {31'b0, event_irq}, 0);
        rd(4'd5, v); chk("R2 command offset reads 0", v, 0);
        rd(4'd12, v); chk("R2 undecoded offset reads 0", v, 0);
    endtask

    task automatic t_plug();
        logic [31:0] v;
        hw_plug(3'd2, 1'b0);
        flags_of(2, v); chk("R10 cold plug present only", v, 1);
        chk("R11 irq low without events", {31'b0, event_irq}, 0);
        hw_plug(3'd5, 1'b1);
        flags_of(5, v); chk("R10 hot plug sets insert", v, 3);
        chk("R11 irq high with event", {31'b0, event_irq}, 1);
        hw_rmreq(3'd2);
        flags_of(2, v); chk("R10 removal request sets remove", v, 5);
        hw_rmreq(3'd5);
        flags_of(5, v); chk("R2 flags bit layout", v, 7);
    endtask

    task automatic t_search();
        logic [31:0] v;
        wr(4'd0, 3); wr(4'd5, 0);
        rd(4'd8, v); chk("R6 search forward to 5", v, 5);
        chk("R7 data returns selector", v, 5);
        wr(4'd0, 6); wr(4'd5, 0);
        rd(4'd8, v); chk("R6 search wraps to 2", v, 2);
        wr(4'd0, 5); wr(4'd5, 0);
        rd(4'd8, v); chk("R6 search starts at selector", v, 5);
        wr(4'd4, 32'h6);
        rd(4'd4, v); chk("R3 bit1 wins over bit2", v, 5);
        wr(4'd4, 32'h4);
        rd(4'd4, v); chk("R3 bit2 clears remove", v, 1);
        flags_of(2, v);
        wr(4'd4, 32'h4);
        rd(4'd4, v); chk("R3 remove cleared on slot 2", v, 1);
        chk("R11 irq drops when none pending", {31'b0, event_irq}, 0);
        wr(4'd0, 5); wr(4'd5, 0);
        rd(4'd8, v); chk("R6 no hit keeps selector", v, 5);
    endtask

    task automatic t_cmd();
        logic [31:0] v;
        wr(4'd5, 1);
        rd(4'd8, v); chk("R7 data reads 0 under command 1", v, 0);
        wr(4'd5, 0);
        wr(4'd5, 3);
        rd(4'd8, v); chk("R5 code 3 ignored", v, 5);
        wr(4'd5, 32'hFF);
        rd(4'd8, v); chk("R5 code 255 ignored", v, 5);
    endtask

    task automatic t_ost();
        logic [31:0] v;
        wr(4'd5, 1);
        wr(4'd8, 32'hA5A5_0001);
        chk("R8 no notify on event word", {31'b0, ost_valid}, 0);
        wr(4'd5, 2);
        wr(4'd8, 32'h0000_0080);
        chk("R8 notify pulse", {31'b0, ost_valid}, 1);
        chk("R8 notify slot", {29'b0, ost_slot}, 5);
        chk("R8 notify event word", ost_event, 32'hA5A5_0001);
        chk("R8 notify status word", ost_status, 32'h80);
        @(negedge clk);
        chk("R8 notify lasts one cycle", {31'b0, ost_valid}, 0);
        wr(4'd5, 0);
        rd(4'd8, v); chk("R7 back to find", v, 5);
    endtask

    task automatic t_eject();
        wr(4'd0, 5);
        wr(4'd4, 32'h8);
        chk("R4 eject pulse", {31'b0, eject_pulse}, 1);
        chk("R4 eject slot", {29'b0, eject_slot}, 5);
        @(negedge clk);
        chk("R4 eject one cycle", {31'b0, eject_pulse}, 0);
        wr(4'd4, 32'hA);
        chk("R3 insert clear blocks eject", {31'b0, eject_pulse}, 0);
        wr(4'd0, 0);
        wr(4'd4, 32'h8);
        chk("R4 absent slot no eject", {31'b0, eject_pulse}, 0);
    endtask

    task automatic t_oor();
        logic [31:0] v;
        hw_plug(3'd1, 1'b1);
        wr(4'd0, 9);
        rd(4'd4, v); chk("R9 flags read 0 out of range", v, 0);
        rd(4'd8, v); chk("R9 data read 0 out of range", v, 0);
        wr(4'd5, 1);
        wr(4'd4, 32'h2);
        wr(4'd4, 32'h8);
        chk("R9 eject dropped", {31'b0, eject_pulse}, 0);
        flags_of(1, v); chk("R9 flags write dropped", v, 3);
        rd(4'd8, v); chk("R9 command write dropped", v, 1);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(4'd0, 1);
        @(negedge clk);
        bus_addr = 4'd4; bus_wr = 1'b1; bus_wdata = 32'h2;
        plug_valid = 1'b1; plug_slot = 3'd1; plug_hot = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; plug_valid = 1'b0; plug_hot = 1'b0;
        rd(4'd4, v); chk("R12 insert set beats clear", v, 3);
        chk("R12 irq held", {31'b0, event_irq}, 1);
        wr(4'd4, 32'h2);
        rd(4'd4, v); chk("R12 later clear works", v, 1);
        @(negedge clk);
        bus_addr = 4'd4; bus_wr = 1'b1; bus_wdata = 32'h4;
        rmreq_valid = 1'b1; rmreq_slot = 3'd1;
        @(negedge clk);
        bus_wr = 1'b0; rmreq_valid = 1'b0;
        rd(4'd4, v); chk("R12 remove set beats clear", v, 5);
        wr(4'd4, 32'h4);
        hw_rmdone(3'd1);
        rd(4'd4, v); chk("R10 removal done clears present", v, 0);
        chk("R11 irq low at end", {31'b0, event_irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plug();
        t_search();
        t_cmd();
        t_ost();
        t_eject();
        t_oor();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule